// File: doc/BRIEF.md
# BCD Time-Calendar Counter

This block is the timekeeping core of a real-time clock. A prescaler divides the slow clock into a one-second tick. Each tick advances a packed-BCD time-of-day word (seconds, minutes, hours and a PM flag) and a packed-BCD calendar word (century, year, month, day of week, day of month). The calendar word knows the length of each month and the leap-year rule from 1900 through 2099. A small register bus reads every word. It writes the control, mode and status-clear words at any time, but writes time and calendar only under a stop handshake.

To load a new time, software sets a stop request for the time word, the calendar word, or both. On the next tick the matching counters have already stopped, and the block raises an acknowledge flag. Only after that do writes to the stopped word take effect. Clearing the request lets counting resume from the loaded value. The tick never splits a second, because the prescaler keeps running during a stop. Sticky status flags mark every tick, every minute change and every day change. Software clears them by writing ones.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, time reads 0x00000000, calendar reads 0x01210020 (year 2000, month 01, weekday 1, date 01), and control, mode and status (addresses 0, 1, 4) all read 0.
- R2: One tick occurs every PRESCALE clock cycles. Each tick sets status bit 2, whether or not counting is stopped.
- R3: The time word at address 2 holds BCD seconds in bits 6:0, minutes in 14:8 and hours in 21:16, with bit 22 as the PM flag. Seconds roll from 59 to 00 into minutes, and minutes roll from 59 to 00 into hours. Status bit 3 is set on every tick that wraps seconds to 00.
- R4: In 24-hour mode (mode bit 0 = 0), hours run 00..23, bit 22 stays 0, and 23 rolls to 00 into the next day. In 12-hour mode (mode bit 0 = 1), hours run 12, 01..11. The step 11→12 toggles bit 22 (1 = PM), and 11 PM → 12 AM starts the next day.
- R5: The calendar word at address 3 holds BCD century in bits 6:0, year in 15:8, month in 20:16, weekday in 23:21 and date in 29:24. The date wraps to 01 after day 31, or after day 30 in months 04, 06, 09 and 11, and that wrap carries into the month. Status bit 4 is set when the calendar advances by one day.
- R6: February has 29 days when the year is divisible by 4, except year 00 of century 19. Otherwise it has 28 days.
- R7: Month 12 wraps to 01 into the year, and year 99 wraps to 00 into the century. The weekday counts 1..7 and wraps from 7 to 1.
- R8: Control bit 0 stops the time counters and control bit 1 stops the calendar counters. Once a bit is set, its counters stop advancing. On the first tick after the request, status bit 0 (acknowledge) is set once.
- R9: A write to the time (or calendar) word takes effect only when its stop request has been acknowledged by a tick. Otherwise the write is ignored.
- R10: Clearing a stop request resumes counting from the value written while stopped, and the next tick advances it by one second.
- R11: A write to address 5 clears exactly the status bits written as 1 and leaves the others unchanged.
- R12: The two stop requests are independent. With only the calendar stopped, time keeps running across midnight while the date holds and status bit 4 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that drives the prescaler and all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address: 0 control, 1 mode, 2 time, 3 calendar, 4 status, 5 status clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The counting function is driven by directed starting points placed one or two seconds before each boundary: end of hour and day, end of 30- and 31-day months, February in a plain year, in a leap year, in 1900 and in 2000, year and century ends, and the 11/12 o'clock steps in 12-hour mode. These separate the month-length, leap and carry chains from one another. Random starting points biased toward the last second, minute, hour and day of the month, in either hour mode, then check the same chain against an independent date model. The handshake runs as ordered sequences: a write before the acknowledge, a write after it, a calendar-only stop across midnight, and a partial status clear. Each sequence shows whether the gating follows the request or the acknowledge.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int ST_W   = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] A_SCLR = 3'd5;

    localparam int ST_ACK = 0;
    localparam int ST_SEC = 2;
    localparam int ST_MIN = 3;
    localparam int ST_DAY = 4;

    typedef struct packed {
        logic       pm;
        logic [5:0] hour;
        logic [6:0] minute;
        logic [6:0] second;
    } tod_t;

    typedef struct packed {
        logic [6:0] century;
        logic [7:0] year;
        logic [4:0] month;
        logic [2:0] wday;
        logic [5:0] mday;
    } cal_t;

    localparam tod_t TOD_RESET = '{pm: 1'b0, hour: 6'h00, minute: 7'h00, second: 7'h00};
    localparam cal_t CAL_RESET = '{century: 7'h20, year: 8'h00, month: 5'h01,
                                   wday: 3'd1, mday: 6'h01};

    // Two-digit BCD increment without wrap handling
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [DATA_W-1:0] tod_to_word(input tod_t t);
        return {9'd0, t.pm, t.hour, 1'b0, t.minute, 1'b0, t.second};
    endfunction

    function automatic logic [DATA_W-1:0] cal_to_word(input cal_t c);
        return {2'd0, c.mday, c.wday, c.month, c.year, 1'b0, c.century};
    endfunction

    function automatic tod_t word_to_tod(input logic [DATA_W-1:0] w);
        tod_t t;
        t.second = w[6:0];
        t.minute = w[14:8];
        t.hour   = w[21:16];
        t.pm     = w[22];
        return t;
    endfunction

    function automatic cal_t word_to_cal(input logic [DATA_W-1:0] w);
        cal_t c;
        c.century = w[6:0];
        c.year    = w[15:8];
        c.month   = w[20:16];
        c.wday    = w[23:21];
        c.mday    = w[29:24];
        return c;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d      = ps_q;
        ps_d.tick = (ps_q.cnt == LAST);
        ps_d.cnt  = (ps_q.cnt == LAST) ? '0 : ps_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign tick_o = ps_q.tick;

    // R2: a tick is a single-cycle pulse
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/rtc_tod_counter.sv
`timescale 1ns/1ps
module rtc_tod_counter import rtc_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic h12_i,
    input  logic wr_i,
    input  tod_t wr_val_i,
    output tod_t tod_o,
    output logic min_evt_o,
    output logic day_evt_o
);
    tod_t tod_d, tod_q;

    logic       step;
    logic       wrap_s, wrap_m, roll_day;
    logic [7:0] s_inc, m_inc, h_inc;
    logic [5:0] hr_n;
    logic       pm_n;

    always_comb begin
        tod_d  = tod_q;
        step   = tick_i & run_i;
        wrap_s = (tod_q.second == 7'h59);
        wrap_m = (tod_q.minute == 7'h59);
        s_inc  = bcd_step({1'b0, tod_q.second});
        m_inc  = bcd_step({1'b0, tod_q.minute});
        h_inc  = bcd_step({2'b00, tod_q.hour});
        roll_day = 1'b0;
        hr_n   = h_inc[5:0];
        pm_n   = tod_q.pm;

        if (h12_i) begin
            if (tod_q.hour == 6'h11) begin
                hr_n     = 6'h12;
                pm_n     = ~tod_q.pm;
                roll_day = tod_q.pm;
            end else if (tod_q.hour == 6'h12) begin
                hr_n = 6'h01;
            end
        end else begin
            pm_n = 1'b0;
            if (tod_q.hour == 6'h23) begin
                hr_n     = 6'h00;
                roll_day = 1'b1;
            end
        end

        if (wr_i) begin
            tod_d = wr_val_i;
        end else if (step) begin
            if (wrap_s) begin
                tod_d.second = 7'h00;
                if (wrap_m) begin
                    tod_d.minute = 7'h00;
                    tod_d.hour   = hr_n;
                    tod_d.pm     = pm_n;
                end else begin
                    tod_d.minute = m_inc[6:0];
                end
            end else begin
                tod_d.second = s_inc[6:0];
            end
        end

        min_evt_o = step & ~wr_i & wrap_s;
        day_evt_o = step & ~wr_i & wrap_s & wrap_m & roll_day;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tod_q <= TOD_RESET;
        else        tod_q <= tod_d;
    end

    assign tod_o = tod_q;

endmodule

// File: rtl/rtc_cal_counter.sv
`timescale 1ns/1ps
module rtc_cal_counter import rtc_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic wr_i,
    input  cal_t wr_val_i,
    output cal_t cal_o
);
    cal_t cal_d, cal_q;

    logic       div4, leap;
    logic [5:0] last_day;
    logic [7:0] d_inc, mo_inc, y_inc, c_inc;

    always_comb begin
        cal_d = cal_q;

        // BCD divisibility by 4: even tens with units 0/4/8, odd tens with units 2/6
        if (cal_q.year[4])
            div4 = (cal_q.year[3:0] == 4'd2) || (cal_q.year[3:0] == 4'd6);
        else
            div4 = (cal_q.year[3:0] == 4'd0) || (cal_q.year[3:0] == 4'd4) ||
                   (cal_q.year[3:0] == 4'd8);
        leap = div4 && !((cal_q.century == 7'h19) && (cal_q.year == 8'h00));

        case (cal_q.month)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase

        d_inc  = bcd_step({2'b00, cal_q.mday});
        mo_inc = bcd_step({3'b000, cal_q.month});
        y_inc  = bcd_step(cal_q.year);
        c_inc  = bcd_step({1'b0, cal_q.century});

        if (wr_i) begin
            cal_d = wr_val_i;
        end else if (adv_i) begin
            cal_d.wday = (cal_q.wday >= 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
            if (cal_q.mday == last_day) begin
                cal_d.mday = 6'h01;
                if (cal_q.month == 5'h12) begin
                    cal_d.month = 5'h01;
                    if (cal_q.year == 8'h99) begin
                        cal_d.year    = 8'h00;
                        cal_d.century = c_inc[6:0];
                    end else begin
                        cal_d.year = y_inc;
                    end
                end else begin
                    cal_d.month = mo_inc[4:0];
                end
            end else begin
                cal_d.mday = d_inc[5:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    assign cal_o = cal_q;

    // R7: every day step moves the weekday
    assert_wday_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !wr_i) |=> (cal_q.wday != $past(cal_q.wday)));

endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core import rtc_pkg::*; #(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic            req_tod;
        logic            req_cal;
        logic            h12;
        logic            tod_frz;
        logic            cal_frz;
        logic [ST_W-1:0] stat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic tick;
    logic tod_wr, cal_wr, cal_adv, ack_set;
    logic tod_min_evt, tod_day_evt;
    tod_t tod;
    cal_t cal;

    rtc_prescaler #(.DIV(PRESCALE)) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rtc_tod_counter u_tod (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .run_i     (~ctl_q.req_tod),
        .h12_i     (ctl_q.h12),
        .wr_i      (tod_wr),
        .wr_val_i  (word_to_tod(bus_wdata)),
        .tod_o     (tod),
        .min_evt_o (tod_min_evt),
        .day_evt_o (tod_day_evt)
    );

    rtc_cal_counter u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (cal_adv),
        .wr_i     (cal_wr),
        .wr_val_i (word_to_cal(bus_wdata)),
        .cal_o    (cal)
    );

    always_comb begin
        ctl_d   = ctl_q;
        tod_wr  = bus_we && (bus_addr == A_TIME) && ctl_q.tod_frz;
        cal_wr  = bus_we && (bus_addr == A_CAL)  && ctl_q.cal_frz;
        cal_adv = tod_day_evt && !ctl_q.req_cal;
        ack_set = tick && ((ctl_q.req_tod && !ctl_q.tod_frz) ||
                           (ctl_q.req_cal && !ctl_q.cal_frz));

        if (bus_we && (bus_addr == A_CTRL)) begin
            ctl_d.req_tod = bus_wdata[0];
            ctl_d.req_cal = bus_wdata[1];
        end
        if (bus_we && (bus_addr == A_MODE))
            ctl_d.h12 = bus_wdata[0];

        if (!ctl_q.req_tod)  ctl_d.tod_frz = 1'b0;
        else if (tick)       ctl_d.tod_frz = 1'b1;
        if (!ctl_q.req_cal)  ctl_d.cal_frz = 1'b0;
        else if (tick)       ctl_d.cal_frz = 1'b1;

        if (bus_we && (bus_addr == A_SCLR))
            ctl_d.stat = ctl_q.stat & ~bus_wdata[ST_W-1:0];
        if (ack_set)     ctl_d.stat[ST_ACK] = 1'b1;
        if (tick)        ctl_d.stat[ST_SEC] = 1'b1;
        if (tod_min_evt) ctl_d.stat[ST_MIN] = 1'b1;
        if (cal_adv)     ctl_d.stat[ST_DAY] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'({ctl_q.req_cal, ctl_q.req_tod});
            A_MODE:  bus_rdata = DATA_W'(ctl_q.h12);
            A_TIME:  bus_rdata = tod_to_word(tod);
            A_CAL:   bus_rdata = cal_to_word(cal);
            A_STAT:  bus_rdata = DATA_W'(ctl_q.stat);
            default: bus_rdata = '0;
        endcase
    end

    // R8: acknowledge only appears at a tick boundary
    assert_ack_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.stat[ST_ACK]) |-> $past(tick));

    // R8: a pending time request holds the time word
    assert_tod_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.req_tod && !tod_wr) |=> $stable(tod));

    // R9: an unacknowledged time write leaves the time word alone
    assert_tod_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_TIME) && !ctl_q.tod_frz && (ctl_q.req_tod || !tick))
        |=> $stable(tod));

    // R12: a pending calendar request holds the calendar word
    assert_cal_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.req_cal && !cal_wr) |=> $stable(cal));

    // R3: minute event coincides with seconds at 00
    assert_min_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.stat[ST_MIN]) |-> (tod.second == 7'h00));

endmodule

// File: tb/rtc_bcd_core_bench.sv
`timescale 1ns/1ps
module rtc_bcd_core_bench;

    localparam int DIV = 24;
    localparam logic [2:0] AC = 3'd0, AM = 3'd1, AT = 3'd2, ACL = 3'd3, AS = 3'd4, AX = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    rtc_bcd_core #(.PRESCALE(DIV)) u_rtc_bcd_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit h12 = 1'b0;
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=%0d cycles expected=<150000", cyc);
        report();
        $finish;
    end

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) % 10) * 16 + (v % 10));
    endfunction

    function automatic bit is_leap(input int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int days_in(input int mo, input int y);
        case (mo)
            2: return is_leap(y) ? 29 : 28;
            4, 6, 9, 11: return 30;
            default: return 31;
        endcase
    endfunction

    function automatic logic [31:0] exp_tod();
        int  h;
        logic pm;
        if (h12) begin
            h  = (m_hr % 12 == 0) ? 12 : m_hr % 12;
            pm = (m_hr >= 12);
        end else begin
            h  = m_hr;
            pm = 1'b0;
        end
        return (32'(pm) << 22) | (32'(bcd(h)) << 16) | (32'(bcd(m_min)) << 8) | 32'(bcd(m_sec));
    endfunction

    function automatic logic [31:0] exp_cal();
        return (32'(bcd(m_date)) << 24) | (32'(m_dow) << 21) | (32'(bcd(m_mon)) << 16) |
               (32'(bcd(m_year % 100)) << 8) | 32'(bcd(m_year / 100));
    endfunction

    task automatic model_tick(input bit cal_hold, output bit mev, output bit dev);
        bit dc = 1'b0;
        mev = 1'b0;
        dev = 1'b0;
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; mev = 1'b1; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin m_hr = 0; dc = 1'b1; end
            end
        end
        if (dc && !cal_hold) begin
            dev = 1'b1;
            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
            m_date++;
            if (m_date > days_in(m_mon, m_year)) begin
                m_date = 1; m_mon++;
                if (m_mon == 13) begin m_mon = 1; m_year++; end
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic poll(input int bitn, output logic [31:0] st);
        st = 32'd0;
        while (st[bitn] !== 1'b1) br(AS, st);
    endtask

    // one counted second; flags cleared afterwards, results compared
    task automatic tick_wait(input string tag, input bit cal_hold, output logic [31:0] st);
        bit mev, dev;
        logic [31:0] rd;
        poll(2, st);
        bw(AX, 32'h1C);
        model_tick(cal_hold, mev, dev);
        chk({tag, " R3 minute event"}, 32'(st[3]), 32'(mev));
        chk({tag, " R5 day event"}, 32'(st[4]), 32'(dev));
        br(AT, rd);
        chk({tag, " R3 time word"}, rd, exp_tod());
        br(ACL, rd);
        chk({tag, " R5 calendar word"}, rd, exp_cal());
    endtask

    task automatic load(input string tag);
        logic [31:0] st, rd;
        bw(AC, 32'd3);
        poll(0, st);
        bw(AT, exp_tod());
        bw(ACL, exp_cal());
        br(AT, rd);
        chk({tag, " R9 accepted time write"}, rd, exp_tod());
        bw(AX, 32'h1F);
        poll(2, st);
        bw(AC, 32'd0);
        bw(AX, 32'h1F);
        br(ACL, rd);
        chk({tag, " R10 held calendar"}, rd, exp_cal());
    endtask

    task automatic scenario(input string tag, input int y, input int mo, input int d, input int w,
                            input int h, input int mi, input int s, input int n);
        logic [31:0] st;
        m_year = y; m_mon = mo; m_date = d; m_dow = w; m_hr = h; m_min = mi; m_sec = s;
        load(tag);
        for (int i = 0; i < n; i++) tick_wait(tag, 1'b0, st);
    endtask

    initial begin
        logic [31:0] rd, st;
        int c1, c2;
        void'($urandom(32'd20240229));

        repeat (6) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        m_year = 2000; m_mon = 1; m_date = 1; m_dow = 1; m_hr = 0; m_min = 0; m_sec = 0;
        br(AT, rd);  chk("R1 time after reset", rd, 32'h0);
        br(ACL, rd); chk("R1 calendar after reset", rd, exp_cal());
        br(AC, rd);  chk("R1 control after reset", rd, 32'h0);
        br(AM, rd);  chk("R1 mode after reset", rd, 32'h0);
        br(AS, rd);  chk("R1 status after reset", rd, 32'h0);

        // R2 tick period
        poll(2, st); c1 = cyc;
        bw(AX, 32'h4);
        poll(2, st); c2 = cyc;
        chk("R2 tick period", 32'(c2 - c1), 32'(DIV));

        // 24-hour directed boundaries
        scenario("R3 plain", 2023, 1, 15, 7, 12, 34, 58, 3);
        scenario("R7 year end", 2023, 12, 31, 7, 23, 59, 58, 3);
        scenario("R7 century end", 1999, 12, 31, 5, 23, 59, 59, 2);
        scenario("R6 leap 2024 feb28", 2024, 2, 28, 3, 23, 59, 59, 2);
        scenario("R6 leap 2024 feb29", 2024, 2, 29, 4, 23, 59, 59, 2);
        scenario("R6 plain 2023 feb28", 2023, 2, 28, 2, 23, 59, 59, 2);
        scenario("R6 year 1900 feb28", 1900, 2, 28, 3, 23, 59, 59, 2);
        scenario("R6 year 2000 feb28", 2000, 2, 28, 1, 23, 59, 59, 2);
        scenario("R5 april end", 2023, 4, 30, 7, 23, 59, 59, 2);
        scenario("R5 january end", 2023, 1, 31, 2, 23, 59, 59, 2);

        // R4 12-hour mode
        h12 = 1'b1;
        bw(AM, 32'd1);
        br(AM, rd); chk("R4 mode readback", rd, 32'd1);
        scenario("R4 11am to 12pm", 2023, 6, 10, 6, 11, 59, 59, 2);
        scenario("R4 12pm to 1pm", 2023, 6, 10, 6, 12, 59, 59, 2);
        scenario("R4 11pm to 12am", 2023, 6, 10, 6, 23, 59, 59, 2);
        scenario("R4 12am to 1am", 2023, 6, 11, 7, 0, 59, 59, 2);
        h12 = 1'b0;
        bw(AM, 32'd0);
        scenario("R4 24h 23 to 00", 2023, 6, 10, 6, 23, 59, 59, 2);

        // R9 write ignored while running
        bw(AT, 32'h00123456);
        br(AT, rd); chk("R9 time write ignored while running", rd, exp_tod());
        bw(ACL, 32'h15632599);
        br(ACL, rd); chk("R9 calendar write ignored while running", rd, exp_cal());
        tick_wait("R9 after ignored write", 1'b0, st);

        // R8 request, early write, acknowledge on tick, freeze
        bw(AC, 32'd1);
        bw(AT, 32'h00123456);
        br(AT, rd); chk("R9 time write ignored before acknowledge", rd, exp_tod());
        poll(0, st);
        chk("R8 acknowledge together with tick", 32'(st[2]), 32'd1);
        br(AT, rd); chk("R8 time held at acknowledge tick", rd, exp_tod());
        bw(AX, 32'h4);
        br(AS, rd);
        chk("R11 ack kept after clearing tick bit", 32'(rd[0]), 32'd1);
        chk("R11 tick bit cleared", 32'(rd[2]), 32'd0);
        bw(AX, 32'h1F);
        poll(2, st);
        chk("R8 no second acknowledge", 32'(st[0]), 32'd0);
        br(AT, rd); chk("R8 time held while requested", rd, exp_tod());
        m_hr = 7; m_min = 45; m_sec = 30;
        bw(AT, exp_tod());
        bw(AC, 32'd0);
        bw(AX, 32'h1F);
        br(AT, rd); chk("R9 time written after acknowledge", rd, exp_tod());
        tick_wait("R10 resume", 1'b0, st);
        tick_wait("R10 resume", 1'b0, st);

        // R12 calendar-only stop across midnight
        scenario("R12 setup", 2023, 8, 31, 4, 23, 59, 57, 1);
        bw(AC, 32'd2);
        tick_wait("R12 cal stopped", 1'b1, st);
        chk("R12 acknowledge for calendar request", 32'(st[0]), 32'd1);
        tick_wait("R12 cal stopped", 1'b1, st);
        m_year = 2031; m_mon = 3; m_date = 14; m_dow = 5;
        bw(ACL, exp_cal());
        bw(AC, 32'd0);
        bw(AX, 32'h1F);
        br(ACL, rd); chk("R12 calendar written", rd, exp_cal());
        tick_wait("R12 resumed", 1'b0, st);

        // random starting points near rollovers
        for (int it = 0; it < 40; it++) begin
            int y, mo, d, h, mi, s, w;
            bit md;
            md = 1'($urandom_range(1, 0));
            if (md != h12) begin h12 = md; bw(AM, 32'(md)); end
            y  = $urandom_range(2099, 1900);
            mo = $urandom_range(12, 1);
            d  = ($urandom_range(1, 0) == 1) ? days_in(mo, y) : $urandom_range(days_in(mo, y), 1);
            h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
            mi = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
            s  = $urandom_range(59, 57);
            w  = $urandom_range(7, 1);
            scenario("R5 random", y, mo, d, w, h, mi, s, 3);
        end

        report();
        $finish;
    end

endmodule